// File: doc/BRIEF.md
# Multiplexed LCD scan sequencer

This block produces the row-by-row scan of a segment LCD controller that drives up to four backplanes and a configurable number of segment columns (24 by default). It divides its input clock into equal frames and splits each frame into one, two, three or four row slots, depending on the drive mode. For each slot it picks one bit out of every 4-bit display word, latches that column, and turns the row index and the latched column into digital drive codes for the backplane and segment output stages. Analog level generation sits downstream of these codes.

On top of the basic scan, the block provides a frame parity flag for DC-free polarity inversion, whole-display blinking at three rates, bank alternation in the one- and two-row modes, display blanking, and a cascade sync pulse. The sync pulse lets several sequencers share one row phase. Configuration is presented on plain input pins and is taken in only at frame boundaries, so a frame never mixes two settings.

Top module: `lcd_scan_sequencer`

## Requirements
- R1: While `rst` is high and in the cycle after it, every drive code is 00, `row_idx`, `frame_parity`, `sync_out` and `col_latch` are zero, and the first frame after reset runs in four-row mode with blanking applied (display disabled, blink off), whatever the configuration pins hold.
- R2: A frame lasts DIV_NORM clocks, or DIV_PS clocks when power saving is set. It is divided into equal slots, one per row of the mode. `cfg_mode` 0 selects one row, 1 selects two, 2 selects three and 3 selects four. `row_idx` counts up from 0 through the rows of the mode.
- R3: The latched column for row r holds bit b of every word, where word j sits at `ram_words[4j+3:4j]`. b is 0 in one-row mode, r in the other modes, and 2 is added when the upper bank is shown. The word contents are sampled one clock before the slot boundary.
- R4: When `cfg_bank` is 1, one-row mode shows bit 2 and two-row mode shows bits 2 and 3. In three- and four-row modes `cfg_bank` has no effect.
- R5: `cfg_blink` 0 turns blinking off. Codes 1, 2 and 3 give a blink period of BLINK_BASE, 2×BLINK_BASE and 4×BLINK_BASE frames. The first half of each period is shown and the second half is blanked (all codes 00).
- R6: When `cfg_blink_alt` is 1 and blinking is on, one- and two-row modes do not blank. Instead they flip the shown bank during the second half of the period. Three- and four-row modes blank as in R5.
- R7: When `cfg_enable` is 0, every backplane and segment code is 00.
- R8: Backplane codes are 10 when the backplane is selected and 01 when it is not. In four-row mode only backplane `row_idx` is selected. In three-row mode the selected backplane is `row_idx`, and backplane 3 copies backplane 1. In two-row mode backplanes 0 and 2 are selected in row 0, and backplanes 1 and 3 in row 1. In one-row mode all four are selected.
- R9: When not blanked, segment j has code 10 if `col_latch[j]` is 1 and code 01 if it is 0.
- R10: `col_latch` changes only at slot boundaries.
- R11: `frame_parity` toggles once at the end of each frame and holds at all other times.
- R12: `sync_out` is high for exactly the first clock of the last row slot. When `sync_in` is high in any other clock, the next cycle is the second clock of the last row slot.
- R13: Configuration changes made mid-frame take effect only from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Row count minus one |
| cfg_power_save | input | 1 | Selects the short frame divider |
| cfg_enable | input | 1 | Display enable |
| cfg_blink | input | 2 | Blink rate code |
| cfg_blink_alt | input | 1 | Bank alternation instead of blanking |
| cfg_bank | input | 1 | Show upper bank in one- and two-row modes |
| ram_words | input | NSEG*4 | Display words, word j at bits 4j+3..4j |
| sync_in | input | 1 | Cascade sync from another sequencer |
| sync_out | output | 1 | Cascade sync pulse |
| row_idx | output | 2 | Active row |
| bp_drv | output | 8 | Backplane codes, backplane i at bits 2i+1..2i |
| seg_drv | output | NSEG*2 | Segment codes, segment j at bits 2j+1..2j |
| frame_parity | output | 1 | Polarity of the current frame |
| col_latch | output | NSEG | Latched column |

## Verification
The assertions check the structural behaviour on every cycle. They cover the row range and slot bound, one-cycle sync pulses, parity toggling only at frame ends, configuration holding between frames, the latch holding inside a slot, idle codes while disabled, and the backplane duplication patterns. Bit selection, bank swapping, blink phase and period, and the cascade realignment depend on clock counts and word contents. Only the bench's reference model and its directed scenarios can show these, across all four modes in both divider settings.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int BP_COUNT  = 4;
    localparam int WORD_BITS = 4;

    typedef enum logic [1:0] {
        MODE_STATIC  = 2'd0,
        MODE_DUPLEX  = 2'd1,
        MODE_TRIPLEX = 2'd2,
        MODE_QUAD    = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        DRV_IDLE = 2'b00,
        DRV_OFF  = 2'b01,
        DRV_ON   = 2'b10
    } drv_code_e;

    typedef struct packed {
        scan_mode_e mode;
        logic       power_save;
        logic       enable;
        logic [1:0] blink;
        logic       blink_alt;
        logic       bank;
    } scan_cfg_t;

    localparam scan_cfg_t CFG_RESET = '{
        mode:       MODE_QUAD,
        power_save: 1'b0,
        enable:     1'b0,
        blink:      2'b00,
        blink_alt:  1'b0,
        bank:       1'b0
    };

    function automatic logic [1:0] last_row(scan_mode_e m);
        return m;
    endfunction

    function automatic logic can_swap(scan_mode_e m);
        return (m == MODE_STATIC) || (m == MODE_DUPLEX);
    endfunction

    // taps[0..2]: phase bits for the short, middle and long blink period
    function automatic logic blink_half(logic [1:0] sel, logic [2:0] taps);
        case (sel)
            2'd1:    return taps[0];
            2'd2:    return taps[1];
            2'd3:    return taps[2];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic blanked(scan_cfg_t c, logic [2:0] taps);
        return !c.enable ||
               (!(c.blink_alt && can_swap(c.mode)) && blink_half(c.blink, taps));
    endfunction

    function automatic logic [1:0] word_bit(scan_cfg_t c, logic [1:0] row, logic [2:0] taps);
        logic flip;
        logic hi;
        flip = c.blink_alt && blink_half(c.blink, taps);
        hi   = can_swap(c.mode) && (c.bank ^ flip);
        case (c.mode)
            MODE_STATIC: return {hi, 1'b0};
            MODE_DUPLEX: return {hi, row[0]};
            default:     return row;
        endcase
    endfunction

    function automatic logic bp_selected(scan_mode_e m, logic [1:0] idx, logic [1:0] row);
        case (m)
            MODE_STATIC:  return 1'b1;
            MODE_DUPLEX:  return idx[0] == row[0];
            MODE_TRIPLEX: return (idx == 2'd3) ? (row == 2'd1) : (idx == row);
            default:      return idx == row;
        endcase
    endfunction

endpackage

// File: rtl/lcd_scan_timebase.sv
module lcd_scan_timebase
    import lcd_scan_pkg::*;
#(
    parameter int DIV_NORM   = 2880,
    parameter int DIV_PS     = 480,
    parameter int BLINK_BASE = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  scan_cfg_t  cfg_in,
    input  logic       sync_in,
    output scan_cfg_t  cfg_q,
    output scan_cfg_t  cfg_nxt,
    output logic [1:0] row,
    output logic [1:0] row_nxt,
    output logic [2:0] taps,
    output logic [2:0] taps_nxt,
    output logic       slot_end,
    output logic       frame_par,
    output logic       sync_out
);
    localparam int DIV_MAX = (DIV_NORM > DIV_PS) ? DIV_NORM : DIV_PS;
    localparam int CW      = $clog2(DIV_MAX);
    localparam int LB      = $clog2(BLINK_BASE);
    localparam int BCW     = LB + 2;

    logic [CW-1:0]  cnt;
    logic [CW-1:0]  slot_len_m1;
    logic [CW-1:0]  len_tab [8];
    logic [BCW-1:0] bcnt;
    logic [BCW-1:0] bcnt_inc;
    logic           at_last;
    logic           realign;
    logic           frame_end;

    // slot length per {power_save, mode}
    for (genvar g = 0; g < 8; g++) begin : g_len
        localparam int DIV = (g >= 4) ? DIV_PS : DIV_NORM;
        assign len_tab[g] = CW'(DIV / ((g % 4) + 1) - 1);
    end

    always_comb begin
        slot_len_m1 = len_tab[{cfg_q.power_save, cfg_q.mode}];
        at_last     = (row == last_row(cfg_q.mode));
        sync_out    = at_last && (cnt == '0);
        realign     = sync_in && !sync_out;
        slot_end    = (cnt == slot_len_m1) && !realign;
        frame_end   = slot_end && at_last;
        bcnt_inc    = bcnt + BCW'(1);
        taps        = {bcnt[LB+1], bcnt[LB], bcnt[LB-1]};
        cfg_nxt     = at_last ? cfg_in : cfg_q;
        taps_nxt    = at_last ? {bcnt_inc[LB+1], bcnt_inc[LB], bcnt_inc[LB-1]} : taps;
        row_nxt     = at_last ? 2'd0 : row + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            row       <= 2'd0;
            bcnt      <= '0;
            frame_par <= 1'b0;
            cfg_q     <= CFG_RESET;
        end else if (realign) begin
            row <= last_row(cfg_q.mode);
            cnt <= CW'(1);
        end else if (slot_end) begin
            cnt <= '0;
            if (at_last) begin
                row       <= 2'd0;
                frame_par <= !frame_par;
                bcnt      <= bcnt_inc;
                cfg_q     <= cfg_in;
            end else begin
                row <= row + 2'd1;
            end
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assert_row_in_mode_R2: assert property (@(posedge clk) disable iff (rst)
        row <= last_row(cfg_q.mode));
    assert_slot_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= slot_len_m1);
    assert_sync_single_R12: assert property (@(posedge clk) disable iff (rst)
        sync_out |=> !sync_out);
    assert_parity_flip_R11: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (frame_par != $past(frame_par)));
    assert_parity_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(frame_par));
    assert_cfg_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cfg_q));

endmodule

// File: rtl/lcd_scan_colsel.sv
module lcd_scan_colsel
    import lcd_scan_pkg::*;
#(
    parameter int NSEG = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSEG*WORD_BITS-1:0] ram_words,
    input  scan_cfg_t                 cfg_nxt,
    input  logic [1:0]                row_nxt,
    input  logic [2:0]                taps_nxt,
    input  logic                      slot_end,
    output logic [NSEG-1:0]           latch
);
    logic [1:0]      bit_idx;
    logic [NSEG-1:0] col_next;
    logic [NSEG-1:0] shadow;

    assign bit_idx = word_bit(cfg_nxt, row_nxt, taps_nxt);

    for (genvar j = 0; j < NSEG; j++) begin : g_col
        logic [WORD_BITS-1:0] word;
        assign word        = ram_words[WORD_BITS*j +: WORD_BITS];
        assign col_next[j] = word[bit_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            latch  <= '0;
        end else begin
            shadow <= col_next;
            if (slot_end) begin
                latch <= shadow;
            end
        end
    end

    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(latch));

endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
    import lcd_scan_pkg::*;
#(
    parameter int NSEG = 24
) (
    input  scan_cfg_t             cfg,
    input  logic [2:0]            taps,
    input  logic [1:0]            row,
    input  logic [NSEG-1:0]       latch,
    output logic                  blank,
    output logic [BP_COUNT*2-1:0] bp_drv,
    output logic [NSEG*2-1:0]     seg_drv
);
    assign blank = blanked(cfg, taps);

    for (genvar i = 0; i < BP_COUNT; i++) begin : g_bp
        logic sel;
        assign sel             = bp_selected(cfg.mode, 2'(i), row);
        assign bp_drv[2*i +: 2] = blank ? DRV_IDLE : (sel ? DRV_ON : DRV_OFF);
    end

    for (genvar j = 0; j < NSEG; j++) begin : g_seg
        assign seg_drv[2*j +: 2] = blank ? DRV_IDLE : (latch[j] ? DRV_ON : DRV_OFF);
    end

endmodule

// File: rtl/lcd_scan_sequencer.sv
module lcd_scan_sequencer
    import lcd_scan_pkg::*;
#(
    parameter int NSEG       = 24,
    parameter int DIV_NORM   = 2880,
    parameter int DIV_PS     = 480,
    parameter int BLINK_BASE = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            cfg_mode,
    input  logic                  cfg_power_save,
    input  logic                  cfg_enable,
    input  logic [1:0]            cfg_blink,
    input  logic                  cfg_blink_alt,
    input  logic                  cfg_bank,
    input  logic [NSEG*4-1:0]     ram_words,
    input  logic                  sync_in,
    output logic                  sync_out,
    output logic [1:0]            row_idx,
    output logic [7:0]            bp_drv,
    output logic [NSEG*2-1:0]     seg_drv,
    output logic                  frame_parity,
    output logic [NSEG-1:0]       col_latch
);
    scan_cfg_t  cfg_in;
    scan_cfg_t  cfg_q;
    scan_cfg_t  cfg_nxt;
    logic [1:0] row_nxt;
    logic [2:0] taps;
    logic [2:0] taps_nxt;
    logic       slot_end;
    logic       blank;

    always_comb begin
        cfg_in.mode       = scan_mode_e'(cfg_mode);
        cfg_in.power_save = cfg_power_save;
        cfg_in.enable     = cfg_enable;
        cfg_in.blink      = cfg_blink;
        cfg_in.blink_alt  = cfg_blink_alt;
        cfg_in.bank       = cfg_bank;
    end

    lcd_scan_timebase #(
        .DIV_NORM  (DIV_NORM),
        .DIV_PS    (DIV_PS),
        .BLINK_BASE(BLINK_BASE)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .cfg_in   (cfg_in),
        .sync_in  (sync_in),
        .cfg_q    (cfg_q),
        .cfg_nxt  (cfg_nxt),
        .row      (row_idx),
        .row_nxt  (row_nxt),
        .taps     (taps),
        .taps_nxt (taps_nxt),
        .slot_end (slot_end),
        .frame_par(frame_parity),
        .sync_out (sync_out)
    );

    lcd_scan_colsel #(.NSEG(NSEG)) u_colsel (
        .clk      (clk),
        .rst      (rst),
        .ram_words(ram_words),
        .cfg_nxt  (cfg_nxt),
        .row_nxt  (row_nxt),
        .taps_nxt (taps_nxt),
        .slot_end (slot_end),
        .latch    (col_latch)
    );

    lcd_scan_drive #(.NSEG(NSEG)) u_drive (
        .cfg    (cfg_q),
        .taps   (taps),
        .row    (row_idx),
        .latch  (col_latch),
        .blank  (blank),
        .bp_drv (bp_drv),
        .seg_drv(seg_drv)
    );

    assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.enable |-> (bp_drv == '0 && seg_drv == '0));
    assert_static_bp_same_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_STATIC) |->
        (bp_drv[1:0] == bp_drv[3:2] && bp_drv[3:2] == bp_drv[5:4] && bp_drv[5:4] == bp_drv[7:6]));
    assert_triplex_dup_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_TRIPLEX) |-> (bp_drv[7:6] == bp_drv[3:2]));
    assert_quad_one_select_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_QUAD && !blank) |->
        ($countones({bp_drv[7], bp_drv[5], bp_drv[3], bp_drv[1]}) == 1));

endmodule

// File: tb/lcd_scan_sequencer_tb.sv
module lcd_scan_sequencer_tb;
    localparam int NSEG = 24;
    localparam int DIVN = 24;
    localparam int DIVP = 12;
    localparam int BB   = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        mode_i;
    logic              ps_i, en_i, alt_i, bank_i, sync_i;
    logic [1:0]        bl_i;
    logic [NSEG*4-1:0] ram_i;
    logic              sync_out, frame_parity;
    logic [1:0]        row_idx;
    logic [7:0]        bp_drv;
    logic [NSEG*2-1:0] seg_drv;
    logic [NSEG-1:0]   col_latch;

    always #5 clk = ~clk;

    lcd_scan_sequencer #(.NSEG(NSEG), .DIV_NORM(DIVN), .DIV_PS(DIVP), .BLINK_BASE(BB)) u_dut (
        .clk(clk), .rst(rst), .cfg_mode(mode_i), .cfg_power_save(ps_i), .cfg_enable(en_i),
        .cfg_blink(bl_i), .cfg_blink_alt(alt_i), .cfg_bank(bank_i), .ram_words(ram_i),
        .sync_in(sync_i), .sync_out(sync_out), .row_idx(row_idx), .bp_drv(bp_drv),
        .seg_drv(seg_drv), .frame_parity(frame_parity), .col_latch(col_latch));

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fails <= 30) $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_phase(int bl, int bc);
        if (bl == 0) return 1'b0;
        return ((bc / ((BB / 2) << (bl - 1))) % 2) == 1;
    endfunction

    function automatic logic [NSEG-1:0] colbit(logic [NSEG*4-1:0] r, int b);
        logic [NSEG-1:0] c;
        for (int j = 0; j < NSEG; j++) c[j] = r[4*j+b];
        return c;
    endfunction

    function automatic logic [NSEG-1:0] m_col(logic [NSEG*4-1:0] r, int row, int mode,
                                              bit bank, bit alt, int bl, int bc);
        bit hi;
        int b;
        hi = (mode <= 1) && (bank ^ (alt && m_phase(bl, bc)));
        if (mode == 0) b = hi ? 2 : 0;
        else if (mode == 1) b = row + (hi ? 2 : 0);
        else b = row;
        return colbit(r, b);
    endfunction

    // behavioural reference state
    int m_cnt, m_row, m_par, m_bc, m_mode, m_bl;
    bit m_ps, m_en, m_alt, m_bank;
    logic [NSEG-1:0] m_shadow, m_latch;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_row = 0; m_par = 0; m_bc = 0; m_mode = 3; m_bl = 0;
            m_ps = 0; m_en = 0; m_alt = 0; m_bank = 0; m_shadow = '0; m_latch = '0;
        end else begin
            int len, n_row, n_mode, n_bl, n_bc;
            bit last, syn, n_alt, n_bank;
            logic [NSEG-1:0] sh;
            len  = (m_ps ? DIVP : DIVN) / (m_mode + 1);
            last = (m_row == m_mode);
            syn  = last && (m_cnt == 0);
            if (last) begin
                n_row = 0; n_mode = int'(mode_i); n_bl = int'(bl_i); n_alt = alt_i;
                n_bank = bank_i; n_bc = (m_bc + 1) % (4 * BB);
            end else begin
                n_row = m_row + 1; n_mode = m_mode; n_bl = m_bl; n_alt = m_alt;
                n_bank = m_bank; n_bc = m_bc;
            end
            sh = m_col(ram_i, n_row, n_mode, n_bank, n_alt, n_bl, n_bc);
            if (sync_i && !syn) begin
                m_row = m_mode; m_cnt = 1;
            end else if (m_cnt == len - 1) begin
                m_latch = m_shadow;
                m_cnt = 0;
                if (last) begin
                    m_row = 0; m_par ^= 1; m_bc = n_bc; m_mode = n_mode; m_bl = n_bl;
                    m_alt = n_alt; m_bank = n_bank; m_ps = ps_i; m_en = en_i;
                end else begin
                    m_row++;
                end
            end else begin
                m_cnt++;
            end
            m_shadow = sh;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit blank, sel;
            logic [7:0] e_bp;
            logic [NSEG*2-1:0] e_seg;
            blank = !m_en || (!(m_alt && m_mode <= 1) && m_phase(m_bl, m_bc));
            for (int i = 0; i < 4; i++) begin
                if (m_mode == 0) sel = 1;
                else if (m_mode == 1) sel = (i % 2) == m_row;
                else if (m_mode == 2) sel = (i == 3) ? (m_row == 1) : (i == m_row);
                else sel = (i == m_row);
                e_bp[2*i +: 2] = blank ? 2'b00 : (sel ? 2'b10 : 2'b01);
            end
            for (int j = 0; j < NSEG; j++)
                e_seg[2*j +: 2] = blank ? 2'b00 : (m_latch[j] ? 2'b10 : 2'b01);
            check(int'(row_idx) == m_row, "R2 row index", 64'(row_idx), 64'(m_row));
            check(int'(frame_parity) == m_par, "R11 frame parity", 64'(frame_parity), 64'(m_par));
            check(sync_out == (m_row == m_mode && m_cnt == 0), "R12 sync pulse",
                  64'(sync_out), 64'(m_row == m_mode && m_cnt == 0));
            check(col_latch == m_latch, "R3 R10 latched column", 64'(col_latch), 64'(m_latch));
            check(bp_drv == e_bp, "R8 backplane codes", 64'(bp_drv), 64'(e_bp));
            check(seg_drv == e_seg, "R9 segment codes", 64'(seg_drv), 64'(e_seg));
        end
    end

    function automatic logic [NSEG*4-1:0] build_ram(logic [31:0] a, logic [31:0] b);
        logic [NSEG*4-1:0] r;
        for (int j = 0; j < NSEG; j++) r[4*j +: 4] = {~b[j], ~a[j], b[j], a[j]};
        return r;
    endfunction

    task automatic setcfg(input int m, input bit ps, input bit en, input int bl, input bit alt, input bit bk);
        @(negedge clk);
        mode_i = 2'(m); ps_i = ps; en_i = en; bl_i = 2'(bl); alt_i = alt; bank_i = bk;
    endtask

    task automatic wait_row(input logic [1:0] r);
        int g = 0;
        while (row_idx != r && g < 2000) begin @(negedge clk); g++; end
    endtask

    task automatic count_blank(input int n, output int nb);
        nb = 0;
        for (int k = 0; k < n; k++) begin @(negedge clk); if (seg_drv == '0) nb++; end
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int nb, hit0, hit2;
        rst = 1; sync_i = 0; ram_i = build_ram(32'h00A5_3C96, 32'h005A_C369);
        mode_i = 2'd0; ps_i = 1; en_i = 1; bl_i = 2'd0; alt_i = 0; bank_i = 0;
        repeat (3) @(negedge clk);
        check(bp_drv == '0 && seg_drv == '0, "R1 idle codes in reset", 64'(seg_drv), 64'd0);
        check(row_idx == 2'd0 && frame_parity == 0 && sync_out == 0, "R1 counters in reset",
              64'({row_idx, frame_parity, sync_out}), 64'd0);
        check(col_latch == '0, "R1 latch in reset", 64'(col_latch), 64'd0);
        rst = 0;
        repeat (6) @(negedge clk);
        check(row_idx == 2'd1, "R1 first frame runs four rows", 64'(row_idx), 64'd1);
        check(seg_drv == '0, "R1 first frame blanked", 64'(seg_drv), 64'd0);

        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 2; p++) begin
                setcfg(m, p[0], 1, 0, 0, 0);
                repeat (4 * DIVN) @(negedge clk);
            end

        setcfg(1, 0, 1, 0, 0, 0);
        repeat (2 * DIVN) @(negedge clk);
        wait_row(2'd1);
        check(col_latch == colbit(ram_i, 1), "R3 two-row row 1 shows bit 1",
              64'(col_latch), 64'(colbit(ram_i, 1)));

        for (int m = 0; m < 4; m++) begin
            setcfg(m, 0, 1, 0, 0, 1);
            repeat (3 * DIVN) @(negedge clk);
        end
        setcfg(0, 0, 1, 0, 0, 1);
        repeat (2 * DIVN) @(negedge clk);
        check(col_latch == colbit(ram_i, 2), "R4 one-row bank shows bit 2",
              64'(col_latch), 64'(colbit(ram_i, 2)));
        setcfg(2, 0, 1, 0, 0, 1);
        repeat (2 * DIVN) @(negedge clk);
        wait_row(2'd1);
        check(col_latch == colbit(ram_i, 1), "R4 three-row ignores bank",
              64'(col_latch), 64'(colbit(ram_i, 1)));

        for (int b = 1; b < 4; b++) begin
            setcfg(3, 0, 1, b, 0, 0);
            repeat (2 * DIVN) @(negedge clk);
            count_blank((BB << (b - 1)) * DIVN, nb);
            check(nb == (BB << (b - 1)) * DIVN / 2, "R5 blink blanks half the period",
                  64'(nb), 64'((BB << (b - 1)) * DIVN / 2));
        end
        setcfg(1, 1, 1, 2, 0, 0);
        repeat (6 * DIVP * BB) @(negedge clk);

        ram_i = build_ram(32'h0012_F0E1, 32'h00C3_0F55);
        setcfg(1, 0, 1, 1, 1, 0);
        repeat (2 * DIVN) @(negedge clk);
        nb = 0; hit0 = 0; hit2 = 0;
        for (int k = 0; k < 2 * BB * DIVN; k++) begin
            @(negedge clk);
            if (seg_drv == '0) nb++;
            if (row_idx == 2'd0 && col_latch == colbit(ram_i, 0)) hit0++;
            if (row_idx == 2'd0 && col_latch == colbit(ram_i, 2)) hit2++;
        end
        check(nb == 0, "R6 alternation never blanks", 64'(nb), 64'd0);
        check(hit0 > 0 && hit2 > 0, "R6 alternation swaps banks", 64'({hit0, hit2}), 64'd1);
        setcfg(3, 0, 1, 1, 1, 0);
        repeat (2 * DIVN) @(negedge clk);
        count_blank(BB * DIVN, nb);
        check(nb == BB * DIVN / 2, "R6 four-row alternation blanks", 64'(nb), 64'(BB * DIVN / 2));

        setcfg(2, 0, 0, 0, 0, 0);
        repeat (2 * DIVN) @(negedge clk);
        count_blank(DIVN, nb);
        check(nb == DIVN, "R7 disabled output idle", 64'(nb), 64'(DIVN));
        check(bp_drv == '0, "R7 backplanes idle", 64'(bp_drv), 64'd0);

        setcfg(3, 0, 1, 0, 0, 0);
        repeat (2 * DIVN) @(negedge clk);
        wait_row(2'd1);
        mode_i = 2'd0;
        begin
            int g = 0;
            while (row_idx == 2'd1 && g < 100) begin @(negedge clk); g++; end
        end
        check(row_idx == 2'd2, "R13 mid-frame mode change deferred", 64'(row_idx), 64'd2);
        repeat (2 * DIVN) @(negedge clk);

        setcfg(3, 0, 1, 0, 0, 0);
        repeat (2 * DIVN) @(negedge clk);
        wait_row(2'd1);
        sync_i = 1;
        @(negedge clk);
        sync_i = 0;
        check(row_idx == 2'd3, "R12 sync realigns to last row", 64'(row_idx), 64'd3);
        repeat (3 * DIVN) @(negedge clk);
        setcfg(2, 1, 1, 0, 0, 0);
        repeat (DIVP + 5) @(negedge clk);
        sync_i = 1;
        @(negedge clk);
        sync_i = 0;
        repeat (3 * DIVP) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule